// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a 32-bit interval timer with three registers on a plain single-cycle register bus: a count, a limit and a control word. While counting is allowed, the count advances by one on every clock. When it equals the limit it returns to zero on the next active edge. If interrupts are enabled at that moment, a pending flag is latched and a level interrupt is raised. Software clears the pending flag by writing the control word.

Two uses are typical. As an event source, software loads the limit with the wanted interval, writes the count to zero and enables both counting and the interrupt. The interrupt handler then writes the control word to acknowledge, either keeping the enable set for periodic ticks or dropping it for a single shot. As a timestamp source, the limit is set to all ones with interrupts off, and the count then runs as a free 32-bit counter that wraps to zero.

Counting is allowed only when the not-halted control bit is set and the core halt input is low. Reset leaves every register at zero, so the timer starts halted with interrupts off.

Top module: `interval_timer`

## Requirements
- R1: After reset the count, limit and control registers all read 0 and `irq` is low.
- R2: The count rises by exactly one per clock while control bit 1 (not-halted) is 1 and `core_halt` is 0.
- R3: The count holds its value when control bit 1 is 0 or `core_halt` is 1.
- R4: On an active cycle where the count equals the limit, the next count value is 0.
- R5: Control bit 3 (pending) is set on the same edge as an R4 wrap if control bit 0 (interrupt enable) is 1 at that cycle. It stays clear on a wrap with the enable at 0.
- R6: `irq` is high exactly while both pending and enable are 1. It stays high across later counting until software acknowledges it.
- R7: Any control write clears pending. Only bit 0 (enable) and bit 1 (not-halted) take the written data; bit 3 and all other bits read back 0 after writing all ones.
- R8: A count write loads the written value at the next edge, overriding that edge's increment or wrap. A wrap that coincides with a count write does not set pending.
- R9: With the limit at all ones and the enable at 0, the count passes from FFFFFFFF to 0 and pending stays clear.
- R10: Register addresses: 0 is count, 1 is limit, 2 is control. Address 3 reads 0 and a write to it changes no register.
- R11: If a wrap with the enable set and a control write happen on the same edge, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| core_halt | input | 1 | High while the core is halted; freezes counting |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is two events landing on one edge: a wrap with a software write, either to the control word (R11) or to the count (R8). From the ports this needs the count parked exactly on the limit at the moment of the write. The bench gets there by holding `core_halt` high while it loads the count and limit. It then drops the halt for a single edge that carries the write. Because the count is frozen outside those windows, every expected count value is exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned TMR_DATA_W   = 32;
    localparam int unsigned TMR_ADDR_W   = 2;
    localparam int unsigned CTRL_IE_BIT  = 0;
    localparam int unsigned CTRL_NH_BIT  = 1;
    localparam int unsigned CTRL_PND_BIT = 3;
    localparam int unsigned CTRL_IMG_W   = CTRL_PND_BIT + 1;

    typedef enum logic [TMR_ADDR_W-1:0] {
        REG_COUNT = 2'd0,
        REG_LIMIT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_VOID  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pend;
        logic nh;
        logic ie;
    } ctrl_t;

    typedef struct packed {
        logic count;
        logic limit;
        logic ctrl;
    } wr_strobe_t;

    function automatic logic [CTRL_IMG_W-1:0] ctrl_image(input ctrl_t c);
        logic [CTRL_IMG_W-1:0] img;
        img               = '0;
        img[CTRL_IE_BIT]  = c.ie;
        img[CTRL_NH_BIT]  = c.nh;
        img[CTRL_PND_BIT] = c.pend;
        return img;
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = TMR_DATA_W,
    parameter int unsigned ADDR_W = TMR_ADDR_W
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] count_q,
    input  logic [DATA_W-1:0] limit_q,
    input  ctrl_t             ctrl_q,
    output wr_strobe_t        wr_stb,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - CTRL_IMG_W;

    logic [DATA_W-1:0] ctrl_word;
    logic              wr_go;

    assign ctrl_word = {{PAD_W{1'b0}}, ctrl_image(ctrl_q)};
    assign wr_go     = bus_sel && bus_we;

    always_comb begin
        wr_stb       = '0;
        wr_stb.count = wr_go && (bus_addr == ADDR_W'(REG_COUNT));
        wr_stb.limit = wr_go && (bus_addr == ADDR_W'(REG_LIMIT));
        wr_stb.ctrl  = wr_go && (bus_addr == ADDR_W'(REG_CTRL));
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (bus_addr)
                ADDR_W'(REG_COUNT): rdata = count_q;
                ADDR_W'(REG_LIMIT): rdata = limit_q;
                ADDR_W'(REG_CTRL):  rdata = ctrl_word;
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              wr_count,
    input  logic              wr_limit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              hit
);

    logic match;
    logic [DATA_W-1:0] count_nx;

    assign match = (count_q == limit_q);
    assign hit   = active && match && !wr_count;

    always_comb begin
        count_nx = count_q;
        if (wr_count)
            count_nx = wdata;
        else if (active)
            count_nx = match ? '0 : count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            limit_q <= '0;
        end else begin
            count_q <= count_nx;
            if (wr_limit)
                limit_q <= wdata;
        end
    end

    // R2: one step per active cycle below the limit
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        active && !wr_count && (count_q != limit_q) |=> count_q == $past(count_q) + 1'b1);

    // R3: frozen when not active
    p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        !active && !wr_count |=> $stable(count_q));

    // R4: wrap to zero at the limit
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        active && !wr_count && (count_q == limit_q) |=> count_q == '0);

    // R8: software load wins
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> count_q == $past(wdata));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  logic  wd_ie,
    input  logic  wd_nh,
    input  logic  hit,
    input  logic  core_halt,
    output ctrl_t ctrl_q,
    output logic  active,
    output logic  irq
);

    logic set_pend;

    assign set_pend = hit && ctrl_q.ie;
    assign active   = ctrl_q.nh && !core_halt;
    assign irq      = ctrl_q.pend && ctrl_q.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ie <= wd_ie;
                ctrl_q.nh <= wd_nh;
            end
            if (set_pend)
                ctrl_q.pend <= 1'b1;
            else if (wr_ctrl)
                ctrl_q.pend <= 1'b0;
        end
    end

    // R5: wrap with enable latches pending (also covers R11 with a write)
    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        hit && ctrl_q.ie |=> ctrl_q.pend);

    // R5: pending only ever rises while enable was on
    p_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.pend) |-> $past(ctrl_q.ie));

    // R7: plain control write clears pending
    p_ack_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl && !(hit && ctrl_q.ie) |=> !ctrl_q.pend);

    // R6: pending persists until a control write
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pend && !wr_ctrl |=> ctrl_q.pend);

    // R6: interrupt rises only from an enabled wrap
    p_irq_src_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(hit && ctrl_q.ie));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = TMR_DATA_W,
    parameter int unsigned ADDR_W = TMR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_halt,
    output logic              irq
);

    wr_strobe_t        wr_stb;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] limit_q;
    logic              active;
    logic              hit;

    tmr_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .count_q  (count_q),
        .limit_q  (limit_q),
        .ctrl_q   (ctrl_q),
        .wr_stb   (wr_stb),
        .rdata    (bus_rdata)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .wr_count (wr_stb.count),
        .wr_limit (wr_stb.limit),
        .wdata    (bus_wdata),
        .count_q  (count_q),
        .limit_q  (limit_q),
        .hit      (hit)
    );

    tmr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_stb.ctrl),
        .wd_ie     (bus_wdata[CTRL_IE_BIT]),
        .wd_nh     (bus_wdata[CTRL_NH_BIT]),
        .hit       (hit),
        .core_halt (core_halt),
        .ctrl_q    (ctrl_q),
        .active    (active),
        .irq       (irq)
    );

    // R10: a write to the unused address touches no register
    p_void_r10: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_we && (bus_addr == ADDR_W'(REG_VOID)) && !active
        |=> $stable(count_q) && $stable(limit_q) && $stable(ctrl_q));

endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_halt = 1'b1;
    logic        irq;

    always #2 clk = ~clk;

    interval_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_halt (core_halt),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    localparam logic [1:0] A_CNT = 2'd0, A_LIM = 2'd1, A_CTL = 2'd2, A_VOID = 2'd3;

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'd0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    // one active edge that also carries a write
    task automatic wr_active(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        core_halt = 0;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; core_halt = 1;
    endtask

    task automatic run(input int n);
        @(posedge clk); #1;
        core_halt = 0;
        repeat (n) @(posedge clk);
        #1 core_halt = 1;
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        exp_reg(A_CNT, 32'h0, "R1 count");
        exp_reg(A_LIM, 32'h0, "R1 limit");
        exp_reg(A_CTL, 32'h0, "R1 ctrl");
        exp_irq(1'b0, "R1 irq");

        // map and unused address
        wr(A_LIM, 32'd1000);
        exp_reg(A_LIM, 32'd1000, "R10 limit");
        wr(A_VOID, 32'hFFFF_FFFF);
        exp_reg(A_VOID, 32'h0, "R10 void read");
        exp_reg(A_LIM, 32'd1000, "R10 limit kept");
        exp_reg(A_CTL, 32'h0, "R10 ctrl kept");
        exp_reg(A_CNT, 32'h0, "R10 count kept");

        // counting
        wr(A_CNT, 32'd10);
        wr(A_CTL, 32'h2);
        run(7);
        exp_reg(A_CNT, 32'd17, "R2 seven steps");

        // halt input freezes
        repeat (5) @(posedge clk);
        exp_reg(A_CNT, 32'd17, "R3 core halt");
        // not-halted bit low freezes
        wr(A_CTL, 32'h0);
        run(5);
        exp_reg(A_CNT, 32'd17, "R3 nh low");

        // wrap with interrupt
        wr(A_LIM, 32'd4);
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h3);
        run(4);
        exp_reg(A_CTL, 32'h3, "R5 not yet");
        run(1);
        exp_reg(A_CNT, 32'd0, "R4 wrap");
        exp_reg(A_CTL, 32'hB, "R5 pending set");
        exp_irq(1'b1, "R6 irq high");
        run(3);
        exp_reg(A_CNT, 32'd3, "R4 after wrap");
        exp_irq(1'b1, "R6 irq held");

        // ack with enable off
        wr(A_CTL, 32'h2);
        exp_reg(A_CTL, 32'h2, "R7 ack");
        exp_irq(1'b0, "R6 irq cleared");
        run(2);
        exp_reg(A_CNT, 32'd0, "R4 second wrap");
        exp_reg(A_CTL, 32'h2, "R5 no set when disabled");

        // writable bits only
        wr(A_CTL, 32'hFFFF_FFFF);
        exp_reg(A_CTL, 32'h3, "R7 masked bits");
        exp_irq(1'b0, "R7 irq low");

        // count write overrides increment
        wr(A_LIM, 32'd1000);
        wr_active(A_CNT, 32'd100);
        run(1);
        exp_reg(A_CNT, 32'd101, "R8 load then step");

        // count write suppresses a wrap
        wr(A_LIM, 32'd7);
        wr(A_CNT, 32'd7);
        wr(A_CTL, 32'h3);
        wr_active(A_CNT, 32'd2);
        exp_reg(A_CNT, 32'd2, "R8 load at limit");
        exp_reg(A_CTL, 32'h3, "R8 no pending");

        // control write on the wrap edge
        wr(A_LIM, 32'd3);
        wr(A_CNT, 32'd3);
        wr_active(A_CTL, 32'h3);
        exp_reg(A_CNT, 32'd0, "R11 wrapped");
        exp_reg(A_CTL, 32'hB, "R11 pending wins");
        exp_irq(1'b1, "R11 irq");
        wr(A_CTL, 32'h3);
        exp_reg(A_CTL, 32'h3, "R7 later ack");

        // free-running full range
        wr(A_CTL, 32'h0);
        wr(A_LIM, 32'hFFFF_FFFF);
        wr(A_CNT, 32'hFFFF_FFFD);
        wr(A_CTL, 32'h2);
        run(2);
        exp_reg(A_CNT, 32'hFFFF_FFFF, "R9 top");
        run(2);
        exp_reg(A_CNT, 32'h1, "R9 wrapped");
        exp_reg(A_CTL, 32'h2, "R9 no pending");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule